// File: doc/BRIEF.md
# LPC I/O Write Snooper with POST-Code Capture

This block listens to an LPC bus as a passive observer. It samples the frame signal and the four-bit multiplexed address/data lines on every rising edge of the bus clock. It never drives the bus. It recognises I/O write cycles only. For every I/O write it publishes the 16-bit address and the 8-bit data byte, together with a one-clock write strobe.

When the decoded address equals the POST port (0x0080 by default), the block also loads a separate POST-code register and raises a one-clock POST strobe. That register holds its value across writes to any other address, so a debug display can always show the latest boot-progress code. Reads, memory, DMA and firmware cycles are dropped as soon as their cycle-type nibble is seen. The turnaround and sync nibbles that follow a write are ignored until the next frame start.

Top module: `lpc_iow_snoop`

## Requirements
- R1: While reset is low and after it is released, `wr_addr`, `wr_data` and `post_code` are zero, and `wr_valid` and `post_valid` are low.
- R2: A frame starts on a clock where `frame_n` is low and `lad` is 0000. If `frame_n` is low with any other `lad` value, no frame starts and the cycle that follows produces no output.
- R3: The nibble sampled on the first clock with `frame_n` high after a start is the cycle type. Only 0010 (I/O write) continues the decode. Any other value returns the block to idle with its outputs unchanged.
- R4: The four nibbles after the cycle type form the address, most significant nibble first.
- R5: The two nibbles after the address form the data byte, least significant nibble first. The sequence A then 5 gives 0x5A.
- R6: Every completed I/O write loads `wr_addr` and `wr_data`, whatever the address. On the clock after the second data nibble is sampled, `wr_valid` is high for exactly one clock.
- R7: `post_code` is loaded, and `post_valid` pulses for one clock, only when the completed write's address equals 0x0080. Writes to any other address, 0x0081 included, leave it unchanged.
- R8: `frame_n` low in the middle of a frame aborts the decode. With `lad` 0000 on that clock a new frame starts; otherwise the block goes idle. An aborted frame changes no output.
- R9: After the second data nibble the block is idle. Nibbles seen with `frame_n` high, including a 0000 sync nibble, are ignored until the next start.
- R10: `post_valid` is never high unless `wr_valid` is high in the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | LPC bus clock; all logic is clocked on its rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| frame_n | input | 1 | Bus frame signal, active low |
| lad | input | 4 | Bus multiplexed nibble lines, sampled only |
| wr_addr | output | 16 | Address of the latest completed I/O write |
| wr_data | output | 8 | Data byte of the latest completed I/O write |
| wr_valid | output | 1 | One-clock strobe when `wr_addr`/`wr_data` update |
| post_code | output | 8 | Last byte written to the POST port |
| post_valid | output | 1 | One-clock strobe when `post_code` updates |

## Verification
The bench mixes several kinds of frame:
- Complete writes to random addresses, weighted toward 0x0080 and its neighbour 0x0081. These separate the address comparison from the general capture path and expose nibble-order mistakes in either field.
- Frames with a bad start code and frames with a non-write cycle type. These must leave every output untouched, which catches any decode that runs without a valid start or type.
- Frames cut short by `frame_n` at every nibble position, either followed by a fresh start on the same clock or left idle. These show whether partial data can leak out and whether a restart is taken on the aborting clock.
- A start held for several clocks, and sync nibbles of 0000 after each write. These check that only the last start clock counts and that idle traffic cannot begin a frame.

// File: rtl/lpc_snoop_pkg.sv
package lpc_snoop_pkg;

  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] START_CODE = 4'b0000;
  localparam logic [NIB_W-1:0] IOW_CODE   = 4'b0010;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_CTYPE = 2'd1,
    PH_ADDR  = 2'd2,
    PH_DATA  = 2'd3
  } phase_e;

endpackage

// File: rtl/lpc_snoop_seq.sv
module lpc_snoop_seq
  import lpc_snoop_pkg::*;
#(
  parameter int ADDR_NIBS = 4,
  parameter int DATA_NIBS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic [NIB_W-1:0] lad,
  output phase_e           phase,
  output logic             take_addr,
  output logic             take_data,
  output logic             commit,
  output logic             frame_start,
  output logic             frame_abort
);

  localparam int MAX_NIBS = (ADDR_NIBS > DATA_NIBS) ? ADDR_NIBS : DATA_NIBS;
  localparam int CNT_W    = $clog2(MAX_NIBS + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_NIBS - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_NIBS - 1);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // Start is judged on every clock while frame_n is low; it beats any phase.
  assign frame_start = !frame_n && (lad == START_CODE);
  assign frame_abort = !frame_n && (phase_q != PH_IDLE);

  always_comb begin
    phase_d   = phase_q;
    cnt_d     = cnt_q;
    take_addr = 1'b0;
    take_data = 1'b0;
    commit    = 1'b0;
    if (!frame_n) begin
      phase_d = frame_start ? PH_CTYPE : PH_IDLE;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          phase_d = PH_IDLE;
        end
        PH_CTYPE: begin
          phase_d = (lad == IOW_CODE) ? PH_ADDR : PH_IDLE;
          cnt_d   = '0;
        end
        PH_ADDR: begin
          take_addr = 1'b1;
          if (cnt_q == ADDR_LAST) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DATA: begin
          take_data = 1'b1;
          if (cnt_q == DATA_LAST) begin
            phase_d = PH_IDLE;
            commit  = 1'b1;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/lpc_snoop_gather.sv
module lpc_snoop_gather
  import lpc_snoop_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NIB_W-1:0]  lad,
  input  logic              take_addr,
  input  logic              take_data,
  output logic [ADDR_W-1:0] addr_acc,
  output logic [DATA_W-1:0] data_word
);

  logic [DATA_W-1:0] data_q;

  // Address nibbles arrive high first: shift left, new nibble at the bottom.
  function automatic logic [ADDR_W-1:0] push_high_first(
    input logic [ADDR_W-1:0] acc, input logic [NIB_W-1:0] nib);
    return {acc[ADDR_W-NIB_W-1:0], nib};
  endfunction

  // Data nibbles arrive low first: shift right, new nibble at the top.
  function automatic logic [DATA_W-1:0] push_low_first(
    input logic [DATA_W-1:0] acc, input logic [NIB_W-1:0] nib);
    return {nib, acc[DATA_W-1:NIB_W]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_acc <= '0;
      data_q   <= '0;
    end else begin
      if (take_addr) addr_acc <= push_high_first(addr_acc, lad);
      if (take_data) data_q   <= push_low_first(data_q, lad);
    end
  end

  // Full byte including the nibble being sampled; valid on the commit clock.
  assign data_word = push_low_first(data_q, lad);

endmodule

// File: rtl/lpc_snoop_publish.sv
module lpc_snoop_publish #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] POST_PORT = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] post_code,
  output logic              post_valid,
  output logic              post_hit
);

  function automatic logic is_post_port(input logic [ADDR_W-1:0] a);
    return a == POST_PORT;
  endfunction

  assign post_hit = is_post_port(addr_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_addr    <= '0;
      wr_data    <= '0;
      wr_valid   <= 1'b0;
      post_code  <= '0;
      post_valid <= 1'b0;
    end else begin
      wr_valid   <= commit;
      post_valid <= commit && post_hit;
      if (commit) begin
        wr_addr <= addr_in;
        wr_data <= data_in;
        if (post_hit) post_code <= data_in;
      end
    end
  end

endmodule

// File: rtl/lpc_iow_snoop.sv
module lpc_iow_snoop
  import lpc_snoop_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] POST_PORT = 16'h0080
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic [3:0]        lad,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_valid,
  output logic [DATA_W-1:0] post_code,
  output logic              post_valid
);

  localparam int ADDR_NIBS = ADDR_W / NIB_W;
  localparam int DATA_NIBS = DATA_W / NIB_W;

  phase_e            seq_phase;
  logic              seq_take_addr;
  logic              seq_take_data;
  logic              seq_commit;
  logic              seq_start;
  logic              seq_abort;
  logic [ADDR_W-1:0] gath_addr;
  logic [DATA_W-1:0] gath_data;
  logic              pub_post_hit;

  lpc_snoop_seq #(
    .ADDR_NIBS(ADDR_NIBS),
    .DATA_NIBS(DATA_NIBS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_n    (frame_n),
    .lad        (lad),
    .phase      (seq_phase),
    .take_addr  (seq_take_addr),
    .take_data  (seq_take_data),
    .commit     (seq_commit),
    .frame_start(seq_start),
    .frame_abort(seq_abort)
  );

  lpc_snoop_gather #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_gather (
    .clk      (clk),
    .rst_n    (rst_n),
    .lad      (lad),
    .take_addr(seq_take_addr),
    .take_data(seq_take_data),
    .addr_acc (gath_addr),
    .data_word(gath_data)
  );

  lpc_snoop_publish #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .POST_PORT(POST_PORT)
  ) u_publish (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit    (seq_commit),
    .addr_in   (gath_addr),
    .data_in   (gath_data),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .post_code (post_code),
    .post_valid(post_valid),
    .post_hit  (pub_post_hit)
  );

endmodule

// File: rtl/lpc_iow_snoop_chk.sv
module lpc_iow_snoop_chk
  import lpc_snoop_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] POST_PORT = 16'h0080
) (
  input logic              clk,
  input logic              rst_n,
  input phase_e            phase,
  input logic              commit,
  input logic              frame_start,
  input logic              frame_abort,
  input logic              post_hit,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_valid,
  input logic [DATA_W-1:0] post_code,
  input logic              post_valid
);

  AST_START_ENTERS_CTYPE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (phase == PH_CTYPE)); // R2

  AST_COMMIT_RAISES_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> wr_valid); // R6

  AST_STROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid); // R6

  AST_WRITE_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> ($stable(wr_addr) && $stable(wr_data))); // R9

  AST_POST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !post_valid |-> $stable(post_code)); // R7

  AST_POST_ADDR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> (wr_addr == POST_PORT)); // R7

  AST_POST_HIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && post_hit) |=> (post_valid && (post_code == wr_data))); // R7

  AST_POST_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    post_valid |-> wr_valid); // R10

  AST_ABORT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_abort |=> !wr_valid); // R8

endmodule

bind lpc_iow_snoop lpc_iow_snoop_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .POST_PORT(POST_PORT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .phase      (seq_phase),
  .commit     (seq_commit),
  .frame_start(seq_start),
  .frame_abort(seq_abort),
  .post_hit   (pub_post_hit),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_valid   (wr_valid),
  .post_code  (post_code),
  .post_valid (post_valid)
);

// File: tb/lpc_iow_snoop_test.sv
module lpc_iow_snoop_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_n;
  logic [3:0]  lad;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_valid;
  logic [7:0]  post_code;
  logic        post_valid;

  int n_checks = 0;
  int n_errs   = 0;

  logic [15:0] exp_addr;
  logic [7:0]  exp_data;
  logic [7:0]  exp_post;

  always #4 clk = ~clk;

  lpc_iow_snoop uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .lad       (lad),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_valid  (wr_valid),
    .post_code (post_code),
    .post_valid(post_valid)
  );

  // Bench's own view of the byte: first nibble on the bus is bits 3:0.
  function automatic logic [7:0] byte_of(input logic [3:0] first, input logic [3:0] second);
    return 8'(second) * 8'd16 + 8'(first);
  endfunction

  // Bench's own view of the address: four nibbles, leading one is most significant.
  function automatic logic [15:0] addr_of(input logic [3:0] n0, input logic [3:0] n1,
                                          input logic [3:0] n2, input logic [3:0] n3);
    return (16'(n0) << 12) | (16'(n1) << 8) | (16'(n2) << 4) | 16'(n3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic f, input logic [3:0] l);
    @(negedge clk);
    frame_n = f;
    lad     = l;
  endtask

  task automatic check_hold(input string req);
    check({req, " wr_valid"},   32'(wr_valid),   32'd0);
    check({req, " post_valid"}, 32'(post_valid), 32'd0);
    check({req, " wr_addr"},    32'(wr_addr),    32'(exp_addr));
    check({req, " wr_data"},    32'(wr_data),    32'(exp_data));
    check({req, " post_code"},  32'(post_code),  32'(exp_post));
  endtask

  // Full I/O write; nibbles are given in bus order.
  task automatic io_write(input logic [3:0] a0, input logic [3:0] a1, input logic [3:0] a2,
                          input logic [3:0] a3, input logic [3:0] d0, input logic [3:0] d1,
                          input int start_clks);
    logic [15:0] a;
    a = addr_of(a0, a1, a2, a3);
    for (int i = 0; i < start_clks; i++) drive(1'b0, 4'h0);
    drive(1'b1, 4'h2);
    drive(1'b1, a0); drive(1'b1, a1); drive(1'b1, a2); drive(1'b1, a3);
    drive(1'b1, d0); drive(1'b1, d1);
    exp_addr = a;
    exp_data = byte_of(d0, d1);
    if (a == 16'h0080) exp_post = exp_data;
    @(negedge clk);
    check("R6 strobe", 32'(wr_valid), 32'd1);
    check("R4 address", 32'(wr_addr), 32'(exp_addr));
    check("R5 data", 32'(wr_data), 32'(exp_data));
    check("R7 post_valid", 32'(post_valid), 32'(a == 16'h0080));
    check("R7 post_code", 32'(post_code), 32'(exp_post));
    frame_n = 1'b1;
    lad     = 4'hF;
    // Sync nibble 0000 with frame high, then random traffic: must be ignored.
    drive(1'b1, 4'h0);
    drive(1'b1, 4'($urandom_range(15)));
    @(negedge clk);
    check_hold("R9 idle after write");
  endtask

  // Start, I/O-write type, then n of the six field nibbles.
  task automatic partial(input logic [15:0] a, input logic [7:0] d, input int n);
    logic [3:0] nib [6];
    nib[0] = a[15:12]; nib[1] = a[11:8]; nib[2] = a[7:4]; nib[3] = a[3:0];
    nib[4] = d[3:0];   nib[5] = d[7:4];
    drive(1'b0, 4'h0);
    drive(1'b1, 4'h2);
    for (int i = 0; i < n; i++) drive(1'b1, nib[i]);
  endtask

  task automatic junk_fields();
    for (int i = 0; i < 6; i++) drive(1'b1, 4'($urandom_range(15)));
  endtask

  function automatic logic [15:0] pick_addr();
    int k;
    k = $urandom_range(7);
    if (k < 2) return 16'h0080;
    if (k == 2) return 16'h0081;
    return 16'($urandom_range(16'hFFFF));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_errs++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [15:0] a;
    logic [7:0]  d;
    void'($urandom(32'd1234));
    rst_n   = 1'b0;
    frame_n = 1'b1;
    lad     = 4'hF;
    exp_addr = '0; exp_data = '0; exp_post = '0;
    repeat (4) @(negedge clk);
    check_hold("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_hold("R1 after reset");

    // Directed: POST write A then 5 gives 0x5A (R5, R7).
    io_write(4'h0, 4'h0, 4'h8, 4'h0, 4'hA, 4'h5, 1);
    check("R5 example byte", 32'(post_code), 32'h5A);
    // Neighbour port leaves POST code alone (R7).
    io_write(4'h0, 4'h0, 4'h8, 4'h1, 4'h6, 4'h7, 1);
    check("R7 0x0081 held", 32'(post_code), 32'h5A);
    // Arbitrary address updates the write outputs (R6, R4).
    io_write(4'hF, 4'h3, 4'h5, 4'h9, 4'h1, 4'h2, 1);
    check("R4 f359", 32'(wr_addr), 32'hF359);
    // Start held for several clocks (R2).
    io_write(4'h0, 4'h0, 4'h8, 4'h0, 4'hC, 4'h3, 3);
    check("R2 long start", 32'(post_code), 32'h3C);
    // Bad start code (R2).
    drive(1'b0, 4'h5); drive(1'b1, 4'h2); junk_fields();
    @(negedge clk);
    check_hold("R2 bad start");
    // Read cycle type (R3).
    drive(1'b0, 4'h0); drive(1'b1, 4'h0); junk_fields();
    @(negedge clk);
    check_hold("R3 read type");
    // Abort after first data nibble, go idle (R8).
    partial(16'h0080, 8'hEE, 5);
    drive(1'b0, 4'h9); junk_fields();
    @(negedge clk);
    check_hold("R8 abort idle");
    // Abort with restart on the same clock (R8).
    partial(16'h1234, 8'h99, 3);
    io_write(4'h0, 4'h0, 4'h8, 4'h0, 4'h4, 4'hB, 1);
    check("R8 restart", 32'(post_code), 32'hB4);

    // Random mix.
    for (int it = 0; it < 400; it++) begin
      int kind;
      kind = $urandom_range(9);
      a = pick_addr();
      d = 8'($urandom_range(255));
      for (int g = 0; g < int'($urandom_range(2)); g++) drive(1'b1, 4'($urandom_range(15)));
      if (kind < 4) begin
        io_write(a[15:12], a[11:8], a[7:4], a[3:0], d[3:0], d[7:4], 1 + $urandom_range(2));
      end else if (kind == 4) begin
        drive(1'b0, 4'($urandom_range(1, 15))); drive(1'b1, 4'h2); junk_fields();
        @(negedge clk);
        check_hold("R2 random bad start");
      end else if (kind == 5) begin
        logic [3:0] t;
        t = 4'($urandom_range(15));
        if (t == 4'h2) t = 4'h3;
        drive(1'b0, 4'h0); drive(1'b1, t);
        drive(1'b1, a[15:12]); drive(1'b1, a[11:8]); drive(1'b1, a[7:4]); drive(1'b1, a[3:0]);
        drive(1'b1, d[3:0]); drive(1'b1, d[7:4]);
        @(negedge clk);
        check_hold("R3 random type");
      end else if (kind < 8) begin
        partial(a, d, $urandom_range(5));
        drive(1'b0, 4'($urandom_range(1, 15))); junk_fields();
        @(negedge clk);
        check_hold("R8 random abort");
      end else begin
        logic [15:0] b;
        logic [7:0]  e;
        b = pick_addr();
        e = 8'($urandom_range(255));
        partial(a, d, $urandom_range(5));
        io_write(b[15:12], b[11:8], b[7:4], b[3:0], e[3:0], e[7:4], 1);
      end
    end

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
    $finish;
  end

endmodule